// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel characters. It runs on a system clock and advances only on cycles where a sampling enable is high. That enable is expected at either sixteen or eight times the bit rate, and a mode input selects which. The raw line first passes through a synchronizer. While idle, the receiver hunts for a falling edge. It accepts a start bit only after the line has stayed low for half a bit time. After that it samples each data bit, an optional parity bit and one stop bit once per bit period, close to the centre of each bit.

Character length (5 to 9 data bits), bit order and parity treatment come from static configuration inputs. These inputs must be held steady while a character is arriving. Each completed character is reported with a one-cycle strobe, in the same cycle as the right-aligned data word, a parity error flag and a framing error flag. Only one stop bit is ever checked. The receiver goes back to hunting in the same sampling tick that samples the stop bit, so back-to-back characters with a single stop bit are accepted.

Top module: `osrx_receiver`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `par_err` and `frm_err` are all 0.
- R2: With `over8`=0 (16x), a start bit is accepted on the 8th consecutive low sample. A low pulse lasting 7 or fewer sampling ticks produces no character.
- R3: With `over8`=1 (8x), a start bit is accepted on the 4th consecutive low sample. A low pulse lasting 3 or fewer sampling ticks produces no character.
- R4: After start acceptance, every further bit is sampled once every 16 ticks (16x) or 8 ticks (8x). Two character strobes are therefore never closer than 6 bit periods at the 8x rate.
- R5: `char_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits. The data word is right-aligned in `rx_data`, with all bits above the character length at 0.
- R6: With `msb_first`=0, the first data bit received lands in `rx_data[0]`. With `msb_first`=1, it lands in `rx_data[n-1]`, where n is the character length.
- R7: `par_mode` code 0 means no parity bit is present and `par_err` stays 0. Codes 1 (even), 2 (odd), 3 (always 0) and 4 (always 1) add a parity bit after the last data bit. `par_err` is 1 exactly when the received parity bit differs from the expected value. For even parity the expected value is the XOR of the data bits; for odd parity it is the inverse of that XOR.
- R8: `frm_err` is 1 when the sampled stop bit is 0, and 0 when it is 1.
- R9: Only one stop bit is checked. Hunting for the next start bit resumes in the tick that samples the stop bit, so characters sent back-to-back with one stop bit are all received, and a second stop bit has no effect.
- R10: `rx_valid` is a one-cycle pulse. `rx_data`, `par_err` and `frm_err` belong to that character in the same cycle.
- R11: Nothing advances on cycles where `samp_en` is 0. A character decodes the same at any enable spacing, and `rx_valid` only follows a cycle with `samp_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sampling tick enable (16x or 8x bit rate) |
| over8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| char_len | input | 3 | Character length code, 0..4 for 5..9 bits |
| msb_first | input | 1 | 1: first data bit is the most significant |
| par_mode | input | 3 | 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1 |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle character-ready strobe |
| par_err | output | 1 | Parity mismatch for the reported character |
| frm_err | output | 1 | Stop bit sampled low for the reported character |

## Verification
Every combination of rate, length, parity mode and bit order is driven with several frame shapes:
- Two characters sent back-to-back with a single stop bit. These separate a receiver that re-arms at the stop sample from one that waits for idle.
- A character with two stop bits, which shows that the extra stop bit is ignored.
- A character whose parity bit has been flipped.
- A character whose stop bit is cut low, each of which must raise only its own flag.

Data patterns include all-zeros, all-ones and mixed values, so that bit-order and alignment faults show up as wrong words. A low pulse one tick shorter than the start threshold tells a correct half-bit validation apart from an edge-triggered start. Some configurations use enables spaced two or three clocks apart, to separate tick-driven timing from clock-driven timing.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0,
      PAR_EVEN = 3'd1,
      PAR_ODD  = 3'd2,
      PAR_ZERO = 3'd3,
      PAR_ONE  = 3'd4
   } par_mode_e;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   // True when the mode code places a parity bit in the frame.
   function automatic logic parity_present(input logic [2:0] mode);
      return (mode >= 3'(PAR_EVEN)) && (mode <= 3'(PAR_ONE));
   endfunction

   // Expected parity bit given the XOR of the received data bits.
   function automatic logic parity_expect(input logic [2:0] mode, input logic data_xor);
      case (mode)
         3'(PAR_EVEN): return data_xor;
         3'(PAR_ODD):  return ~data_xor;
         3'(PAR_ONE):  return 1'b1;
         default:      return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 1) begin : g_single
         logic stage_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_r <= IDLE_LVL;
            else        stage_r <= d;
         end
         assign q = stage_r;
      end else begin : g_chain
         logic [STAGES-1:0] chain_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_r <= {STAGES{IDLE_LVL}};
            else        chain_r <= {chain_r[STAGES-2:0], d};
         end
         assign q = chain_r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/osrx_bit_timer.sv
module osrx_bit_timer #(
   parameter int OVS_HI = 16,
   parameter int OVS_LO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic over8,
   input  logic hunt,
   input  logic line,
   output logic start_found,
   output logic mid_strobe
);

   localparam int CNT_W = $clog2(OVS_HI);

   logic [CNT_W-1:0] cnt_r;
   logic [CNT_W-1:0] full_last;
   logic [CNT_W-1:0] half_last;

   assign full_last = over8 ? CNT_W'(OVS_LO - 1)     : CNT_W'(OVS_HI - 1);
   assign half_last = over8 ? CNT_W'(OVS_LO / 2 - 1) : CNT_W'(OVS_HI / 2 - 1);

   // While hunting the counter measures the run of low samples;
   // afterwards it paces one sample per bit period.
   assign start_found = tick && hunt && !line && (cnt_r == half_last);
   assign mid_strobe  = tick && !hunt && (cnt_r == full_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r <= '0;
      end else if (tick) begin
         if (hunt) begin
            if (line || start_found) cnt_r <= '0;
            else                     cnt_r <= cnt_r + 1'b1;
         end else begin
            if (mid_strobe) cnt_r <= '0;
            else            cnt_r <= cnt_r + 1'b1;
         end
      end
   end

endmodule

// File: rtl/osrx_frame_ctrl.sv
module osrx_frame_ctrl
   import osrx_pkg::*;
#(
   parameter int DATA_W   = 9,
   parameter int MIN_CHAR = 5,
   parameter int LEN_W    = 3,
   localparam int BC_W    = $clog2(DATA_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_found,
   input  logic             mid_strobe,
   input  logic [LEN_W-1:0] char_len,
   input  logic             par_on,
   output logic             hunt,
   output logic             take_data,
   output logic             take_par,
   output logic             take_stop,
   output logic [BC_W-1:0]  n_bits
);

   rx_state_e       st_r;
   logic [BC_W-1:0] bcnt_r;
   logic [BC_W-1:0] last_idx;

   always_comb begin
      if (char_len > LEN_W'(DATA_W - MIN_CHAR)) n_bits = BC_W'(DATA_W);
      else                                      n_bits = BC_W'(MIN_CHAR) + BC_W'(char_len);
   end

   assign last_idx  = n_bits - 1'b1;
   assign hunt      = (st_r == ST_HUNT);
   assign take_data = mid_strobe && (st_r == ST_DATA);
   assign take_par  = mid_strobe && (st_r == ST_PAR);
   assign take_stop = mid_strobe && (st_r == ST_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_r   <= ST_HUNT;
         bcnt_r <= '0;
      end else begin
         case (st_r)
            ST_HUNT: begin
               if (start_found) begin
                  st_r   <= ST_DATA;
                  bcnt_r <= '0;
               end
            end
            ST_DATA: begin
               if (mid_strobe) begin
                  if (bcnt_r == last_idx) st_r <= par_on ? ST_PAR : ST_STOP;
                  else                    bcnt_r <= bcnt_r + 1'b1;
               end
            end
            ST_PAR: begin
               if (mid_strobe) st_r <= ST_STOP;
            end
            default: begin
               if (mid_strobe) st_r <= ST_HUNT;
            end
         endcase
      end
   end

endmodule

// File: rtl/osrx_word_asm.sv
module osrx_word_asm #(
   parameter int DATA_W          = 9,
   parameter bit ALLOW_MSB_FIRST = 1'b1,
   localparam int BC_W           = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              bit_in,
   input  logic              msb_first,
   input  logic [BC_W-1:0]   n_bits,
   output logic [DATA_W-1:0] word,
   output logic              data_xor
);

   logic [DATA_W-1:0] sr_r;
   logic              acc_r;
   logic [DATA_W-1:0] lsb_word;

   // LSB-first bits enter at the top and are moved down at the output.
   assign lsb_word = sr_r >> (BC_W'(DATA_W) - n_bits);
   assign data_xor = acc_r;

   generate
      if (ALLOW_MSB_FIRST) begin : g_both_orders
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_r  <= '0;
               acc_r <= 1'b0;
            end else if (clear) begin
               sr_r  <= '0;
               acc_r <= 1'b0;
            end else if (take) begin
               acc_r <= acc_r ^ bit_in;
               if (msb_first) sr_r <= {sr_r[DATA_W-2:0], bit_in};
               else           sr_r <= {bit_in, sr_r[DATA_W-1:1]};
            end
         end
         assign word = msb_first ? sr_r : lsb_word;
      end else begin : g_lsb_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_r  <= '0;
               acc_r <= 1'b0;
            end else if (clear) begin
               sr_r  <= '0;
               acc_r <= 1'b0;
            end else if (take) begin
               acc_r <= acc_r ^ bit_in;
               sr_r  <= {bit_in, sr_r[DATA_W-1:1]};
            end
         end
         assign word = msb_first ? lsb_word : lsb_word;
      end
   endgenerate

endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver
   import osrx_pkg::*;
#(
   parameter int DATA_W          = 9,
   parameter int MIN_CHAR        = 5,
   parameter int LEN_W           = 3,
   parameter int OVS_HI          = 16,
   parameter int OVS_LO          = 8,
   parameter int SYNC_STAGES     = 2,
   parameter bit ALLOW_MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              over8,
   input  logic [LEN_W-1:0]  char_len,
   input  logic              msb_first,
   input  logic [2:0]        par_mode,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              par_err,
   output logic              frm_err
);

   localparam int BC_W = $clog2(DATA_W + 1);

   initial begin
      if (DATA_W < MIN_CHAR || MIN_CHAR < 1)
         $fatal(1, "osrx_receiver: DATA_W must be at least MIN_CHAR");
      if (MIN_CHAR + (2 ** LEN_W) - 1 < DATA_W)
         $fatal(1, "osrx_receiver: LEN_W too narrow for DATA_W");
      if (OVS_LO < 2 || (OVS_LO % 2) != 0 || (OVS_HI % 2) != 0 || OVS_HI <= OVS_LO)
         $fatal(1, "osrx_receiver: oversampling factors must be even, OVS_HI > OVS_LO >= 2");
      if (SYNC_STAGES < 1)
         $fatal(1, "osrx_receiver: SYNC_STAGES must be at least 1");
   end

   logic              line;
   logic              hunt;
   logic              start_found;
   logic              mid_strobe;
   logic              take_data;
   logic              take_par;
   logic              take_stop;
   logic [BC_W-1:0]   n_bits;
   logic [DATA_W-1:0] word;
   logic              data_xor;
   logic              par_on;
   logic              par_bit_r;

   assign par_on = parity_present(par_mode);

   osrx_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (line)
   );

   osrx_bit_timer #(
      .OVS_HI (OVS_HI),
      .OVS_LO (OVS_LO)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (samp_en),
      .over8       (over8),
      .hunt        (hunt),
      .line        (line),
      .start_found (start_found),
      .mid_strobe  (mid_strobe)
   );

   osrx_frame_ctrl #(
      .DATA_W   (DATA_W),
      .MIN_CHAR (MIN_CHAR),
      .LEN_W    (LEN_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_found (start_found),
      .mid_strobe  (mid_strobe),
      .char_len    (char_len),
      .par_on      (par_on),
      .hunt        (hunt),
      .take_data   (take_data),
      .take_par    (take_par),
      .take_stop   (take_stop),
      .n_bits      (n_bits)
   );

   osrx_word_asm #(
      .DATA_W          (DATA_W),
      .ALLOW_MSB_FIRST (ALLOW_MSB_FIRST)
   ) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_found),
      .take      (take_data),
      .bit_in    (line),
      .msb_first (msb_first),
      .n_bits    (n_bits),
      .word      (word),
      .data_xor  (data_xor)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_bit_r <= 1'b0;
      else if (take_par) par_bit_r <= line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
         par_err  <= 1'b0;
         frm_err  <= 1'b0;
      end else begin
         rx_valid <= take_stop;
         if (take_stop) begin
            rx_data <= word;
            par_err <= par_on && (par_bit_r != parity_expect(par_mode, data_xor));
            frm_err <= !line;
         end
      end
   end

endmodule

// File: rtl/osrx_receiver_chk.sv
module osrx_receiver_chk #(
   parameter int DATA_W   = 9,
   parameter int MIN_CHAR = 5,
   parameter int LEN_W    = 3,
   parameter int OVS_HI   = 16,
   parameter int OVS_LO   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              samp_en,
   input logic [LEN_W-1:0]  char_len,
   input logic [2:0]        par_mode,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              par_err,
   input logic              take_stop,
   input logic              hunt
);

   localparam int GAP_MIN = 6 * OVS_LO;
   localparam int GAP_W   = $clog2(6 * OVS_HI + 2);

   logic [GAP_W-1:0] gap_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       gap_r <= '1;
      else if (rx_valid)                gap_r <= '0;
      else if (samp_en && gap_r != '1)  gap_r <= gap_r + 1'b1;
   end

   assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (char_len <= LEN_W'(DATA_W - MIN_CHAR)))
         |-> ((rx_data >> (MIN_CHAR + int'(char_len))) == '0));

   assert_no_parity_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && par_mode == 3'd0) |-> !par_err);

   assert_frame_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (gap_r >= GAP_W'(GAP_MIN)));

   assert_rehunt_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_stop |=> hunt);

   assert_tick_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(samp_en));

endmodule

bind osrx_receiver osrx_receiver_chk #(
   .DATA_W   (DATA_W),
   .MIN_CHAR (MIN_CHAR),
   .LEN_W    (LEN_W),
   .OVS_HI   (OVS_HI),
   .OVS_LO   (OVS_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_en   (samp_en),
   .char_len  (char_len),
   .par_mode  (par_mode),
   .rx_data   (rx_data),
   .rx_valid  (rx_valid),
   .par_err   (par_err),
   .take_stop (take_stop),
   .hunt      (hunt)
);

// File: tb/osrx_receiver_tb.sv
`timescale 1ns/1ps
module osrx_receiver_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b0;
   logic       over8 = 1'b0;
   logic [2:0] char_len = 3'd3;
   logic       msb_first = 1'b0;
   logic [2:0] par_mode = 3'd0;
   logic       rxd = 1'b1;
   logic [8:0] rx_data;
   logic       rx_valid;
   logic       par_err;
   logic       frm_err;

   int main_vec = 0, main_fail = 0, mon_vec = 0, mon_fail = 0;
   int div = 1;
   int divc = 0;
   bit finished = 1'b0;
   bit prev_valid = 1'b0;
   logic [10:0] exp_q[$];

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (divc >= div - 1) divc <= 0;
      else                 divc <= divc + 1;
      samp_en <= (divc == 0);
   end

   osrx_receiver u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en),
      .over8     (over8),
      .char_len  (char_len),
      .msb_first (msb_first),
      .par_mode  (par_mode),
      .rxd       (rxd),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .par_err   (par_err),
      .frm_err   (frm_err)
   );

   // Character monitor: compares each strobe with the oldest expectation.
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         mon_vec++;
         if (prev_valid) begin
            mon_fail++;
            $display("FAIL R10 strobe longer than one cycle: actual 2+ cycles expected 1");
         end
         if (exp_q.size() == 0) begin
            mon_fail++;
            $display("FAIL R2 R3 R9 unexpected character: actual %h expected none", rx_data);
         end else begin
            logic [10:0] e;
            e = exp_q.pop_front();
            if ({frm_err, par_err, rx_data} !== e) begin
               mon_fail++;
               $display("FAIL R4 R5 R6 R7 R8 len=%0d par=%0d msb=%0d over8=%0d: actual f=%b p=%b d=%h expected f=%b p=%b d=%h",
                        char_len, par_mode, msb_first, over8,
                        frm_err, par_err, rx_data, e[10], e[9], e[8:0]);
            end
         end
      end
      prev_valid <= rst_n && rx_valid;
   end

   function automatic int bitclk();
      return (over8 ? 8 : 16) * div;
   endfunction

   task automatic hold(input logic v, input int clks);
      rxd = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send_char(input logic [8:0] d, input bit bad_par, input bit bad_stop, input int nstop);
      int         n;
      int         bc;
      logic [8:0] dm;
      logic       p;
      n  = 5 + int'(char_len);
      bc = bitclk();
      dm = d & 9'((1 << n) - 1);
      case (par_mode)
         3'd1:    p = ^dm;
         3'd2:    p = ~^dm;
         3'd4:    p = 1'b1;
         default: p = 1'b0;
      endcase
      exp_q.push_back({bad_stop, (par_mode != 3'd0) && bad_par, dm});
      hold(1'b0, bc);
      for (int i = 0; i < n; i++) hold(msb_first ? dm[n-1-i] : dm[i], bc);
      if (par_mode != 3'd0) hold(p ^ bad_par, bc);
      if (bad_stop) begin
         hold(1'b0, bc * 3 / 4);
         hold(1'b1, bc - bc * 3 / 4);
      end else begin
         hold(1'b1, bc * nstop);
      end
   endtask

   task automatic drain(input string tag);
      hold(1'b1, 2 * bitclk());
      main_vec++;
      if (exp_q.size() != 0) begin
         main_fail++;
         $display("FAIL %s characters missing: actual %0d outstanding expected 0", tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      main_vec++;
      if (rx_valid !== 1'b0 || rx_data !== 9'h0 || par_err !== 1'b0 || frm_err !== 1'b0) begin
         main_fail++;
         $display("FAIL R1 reset outputs: actual v=%b d=%h p=%b f=%b expected all 0",
                  rx_valid, rx_data, par_err, frm_err);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      for (int ov = 0; ov < 2; ov++) begin
         for (int ln = 0; ln < 5; ln++) begin
            for (int pm = 0; pm < 5; pm++) begin
               for (int mb = 0; mb < 2; mb++) begin
                  logic [8:0] base;
                  over8     = ov[0];
                  char_len  = 3'(ln);
                  par_mode  = 3'(pm);
                  msb_first = mb[0];
                  // R11: some configurations space the enable 2 or 3 clocks apart
                  div       = (ln == 3 && mb == 1) ? 3 : ((ln == 1) ? 2 : 1);
                  hold(1'b1, 3 * bitclk());
                  if (pm == 0 && mb == 0) begin
                     // R2 / R3: low pulse one tick short of the start threshold
                     hold(1'b0, ((ov == 1) ? 3 : 7) * div);
                     hold(1'b1, 2 * bitclk());
                     drain(ov == 1 ? "R3" : "R2");
                  end
                  base = 9'((ln * 37 + pm * 11 + mb * 5 + ov * 3) & 9'h1FF);
                  // R9: two characters back-to-back with a single stop bit
                  send_char((mb == 1) ? 9'h000 : 9'h1FF, 1'b0, 1'b0, 1);
                  send_char(base ^ 9'h0A5, 1'b0, 1'b0, 1);
                  // R7: flipped parity, R9: two stop bits
                  send_char(base ^ 9'h15A, pm != 0, 1'b0, 2);
                  // R8: stop bit sampled low
                  send_char(base ^ 9'h0C3, 1'b0, 1'b1, 1);
                  send_char(base ^ 9'h13C, 1'b0, 1'b0, 1);
                  drain("R4 R9");
               end
            end
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", main_vec + mon_vec, main_fail + mon_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         main_fail++;
         $display("FAIL R4 watchdog expired: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", main_vec + mon_vec, main_fail + mon_fail);
         $finish;
      end
   end

endmodule